// File: doc/BRIEF.md
# Skew Polarity Decision Latch

This block decides, once per sampling round, whether a channel clock edge came before or after a reference clock edge. It runs in one fast system clock domain. Each edge shows up as a one-cycle arrival strobe. A four-phase round sequence supplies two timing indications. A phase-1 window clears the detector. A phase-3 indication closes the round and publishes the decision.

Inside are two capture elements, one for each edge, that lock each other out. The first strobe to arrive sets its element. That element then stops the other from setting for the rest of the round. Sometimes no element has set by phase 3, either because the strobes coincided or because no edge arrived. In that case a forced-decision flag picks the reference-leads answer. The result is a complementary pair of bits (a, b). The pair is registered at phase 3 together with a one-cycle valid pulse, and it stays unchanged until the next decision, so a downstream up/down counter can consume it. Each channel uses its own instance.

Top module: `skew_polarity_latch`

## Requirements
- R1: While `rst_ni` is low, `a_o`, `b_o`, `fd_o` and `valid_o` are 0 and both capture elements are cleared.
- R2: Outside phase 1, phase 3 and the forced state, the first arrival strobe sets its capture element. That element stays set until the next phase-1 cycle. The opposite element cannot set for the rest of the round.
- R3: A decision is encoded as follows. Channel captured first gives `a_o`=0, `b_o`=1. Reference captured first gives `a_o`=1, `b_o`=0.
- R4: A cycle with `ph1_i` high clears both capture elements and `fd_o`. Strobes seen in that cycle capture nothing.
- R5: If both strobes arrive in the same cycle while neither element is set, neither element sets.
- R6: If neither element is set when `ph3_i` is sampled, `fd_o` rises with the decision. The decision is then `a_o`=1, `b_o`=0, and `fd_o` stays high until the next phase-1 cycle.
- R7: When `ph3_i` is sampled high with `ph1_i` low, `valid_o` is high for exactly the following cycle. `a_o` and `b_o` are updated in that same edge.
- R8: `a_o` and `b_o` change only on a decision. They hold through idle cycles and phase-1 cycles.
- R9: When `ph1_i` and `ph3_i` are high in the same cycle, phase 1 wins. No decision is made and `valid_o` stays low.
- R10: A strobe arriving in a phase-3 cycle, or while `fd_o` is high, captures nothing. A later phase 3 in the same round repeats the forced answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_edge_i | input | 1 | One-cycle strobe marking arrival of the reference edge |
| chan_edge_i | input | 1 | One-cycle strobe marking arrival of the channel edge |
| ph1_i | input | 1 | Phase-1 clear window of the round sequence |
| ph3_i | input | 1 | Phase-3 decision point of the round sequence |
| a_o | output | 1 | Decision bit: 1 when the reference leads or the decision is forced |
| b_o | output | 1 | Decision bit: 1 when the channel leads |
| fd_o | output | 1 | Forced-decision flag for the current round |
| valid_o | output | 1 | One-cycle pulse marking a new decision |

## Verification
Two conditions are hard to reach from the ports. The first is a strobe that arrives while the detector is already committed: the other element is set, the forced flag is up, or the round is at phase 3. The stimulus reaches each of these by arranging strobes within a round: a rival strobe after a capture, two strobes in one cycle after one side already won, a channel strobe in the phase-3 cycle, and a channel strobe followed by a second phase 3 with no phase-1 window between them. The second condition is phase 1 and phase 3 asserted together, which the stimulus applies while the forced flag is up, to show that clearing takes priority over deciding.

// File: rtl/skew_pol_pkg.sv
package skew_pol_pkg;
  localparam int SIDE_REF  = 0;
  localparam int SIDE_CHAN = 1;
  localparam int NUM_SIDES = 2;

  typedef struct packed {
    logic a;
    logic b;
  } decision_t;

  localparam decision_t DEC_RESET     = '{a: 1'b0, b: 1'b0};
  localparam decision_t DEC_REF_LEADS = '{a: 1'b1, b: 1'b0};
  localparam decision_t DEC_CH_LEADS  = '{a: 1'b0, b: 1'b1};
endpackage

// File: rtl/skew_capture_cell.sv
module skew_capture_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic block_i,
  input  logic edge_i,
  input  logic rival_edge_i,
  input  logic rival_set_i,
  output logic set_o
);
  logic set_q;
  logic win;

  // a same-cycle rival strobe is a tie: nobody wins
  assign win = edge_i & ~rival_edge_i & ~rival_set_i & ~block_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      set_q <= 1'b0;
    else if (clear_i) set_q <= 1'b0;
    else if (win)     set_q <= 1'b1;
  end

  assign set_o = set_q;

  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_q && !clear_i) |=> set_q);
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !set_q);
endmodule

// File: rtl/skew_forced_flag.sv
module skew_forced_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph1_i,
  input  logic ph3_i,
  input  logic any_set_i,
  output logic fd_o
);
  logic fd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    fd_q <= 1'b0;
    else if (ph1_i)                 fd_q <= 1'b0;
    else if (ph3_i && !any_set_i)   fd_q <= 1'b1;
  end

  assign fd_o = fd_q;

  p_fd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fd_q && !ph1_i) |=> fd_q);
  p_fd_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph1_i |=> !fd_q);
endmodule

// File: rtl/skew_decision_reg.sv
module skew_decision_reg
  import skew_pol_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph1_i,
  input  logic ph3_i,
  input  logic chan_set_i,
  output logic a_o,
  output logic b_o,
  output logic valid_o
);
  decision_t dec_q;
  logic      valid_q;
  logic      strobe;

  assign strobe = ph3_i & ~ph1_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q   <= DEC_RESET;
      valid_q <= 1'b0;
    end else begin
      valid_q <= strobe;
      if (strobe) dec_q <= chan_set_i ? DEC_CH_LEADS : DEC_REF_LEADS;
    end
  end

  assign a_o     = dec_q.a;
  assign b_o     = dec_q.b;
  assign valid_o = valid_q;

  p_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph3_i && !ph1_i) |=> valid_o);
  p_valid_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ph3_i && !ph1_i) |=> !valid_o);
  p_ph1_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph1_i |=> !valid_o);
  p_compl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (a_o != b_o));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable({a_o, b_o}));
endmodule

// File: rtl/skew_polarity_latch.sv
module skew_polarity_latch
  import skew_pol_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_edge_i,
  input  logic chan_edge_i,
  input  logic ph1_i,
  input  logic ph3_i,
  output logic a_o,
  output logic b_o,
  output logic fd_o,
  output logic valid_o
);
  logic [NUM_SIDES-1:0] edge_w;
  logic [NUM_SIDES-1:0] set_w;
  logic                 block_w;
  logic                 fd_w;

  assign edge_w[SIDE_REF]  = ref_edge_i;
  assign edge_w[SIDE_CHAN] = chan_edge_i;
  // no capture at the decision point or after a forced decision
  assign block_w = ph3_i | fd_w;

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    skew_capture_cell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clear_i      (ph1_i),
      .block_i      (block_w),
      .edge_i       (edge_w[g]),
      .rival_edge_i (edge_w[NUM_SIDES-1-g]),
      .rival_set_i  (set_w[NUM_SIDES-1-g]),
      .set_o        (set_w[g])
    );
  end

  skew_forced_flag u_fd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ph1_i     (ph1_i),
    .ph3_i     (ph3_i),
    .any_set_i (|set_w),
    .fd_o      (fd_w)
  );

  skew_decision_reg u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ph1_i      (ph1_i),
    .ph3_i      (ph3_i),
    .chan_set_i (set_w[SIDE_CHAN]),
    .a_o        (a_o),
    .b_o        (b_o),
    .valid_o    (valid_o)
  );

  assign fd_o = fd_w;

  p_mutex_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(set_w) <= 1);
  p_tie_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_edge_i && chan_edge_i && set_w == '0) |=> (set_w == '0));
  p_forced_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fd_o |-> (a_o && !b_o));
  p_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ph3_i || fd_o) && set_w == '0) |=> (set_w == '0));
  p_fd_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fd_o |-> (set_w == '0));
endmodule

// File: tb/skew_polarity_latch_tb_top.sv
module skew_polarity_latch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_e = 1'b0, chan_e = 1'b0, p1 = 1'b0, p3 = 1'b0;
  logic a, b, fd, v;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_ref = 0, m_chan = 0, m_fd = 0, m_a = 0, m_b = 0, m_v = 0;

  always #5 clk = ~clk;

  skew_polarity_latch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_edge_i(ref_e), .chan_edge_i(chan_e),
    .ph1_i(p1), .ph3_i(p3), .a_o(a), .b_o(b), .fd_o(fd), .valid_o(v)
  );

  task automatic check(string tag);
    n_run++;
    if (a !== m_a[0] || b !== m_b[0] || fd !== m_fd[0] || v !== m_v[0]) begin
      n_fail++;
      $display("FAIL %s: got a=%b b=%b fd=%b v=%b exp a=%0d b=%0d fd=%0d v=%0d",
               tag, a, b, fd, v, m_a, m_b, m_fd, m_v);
    end
  endtask

  task automatic model_step(int r, int c, int ph1, int ph3);
    if (!rst_n) begin
      m_ref = 0; m_chan = 0; m_fd = 0; m_a = 0; m_b = 0; m_v = 0;
    end else if (ph1 != 0) begin
      m_ref = 0; m_chan = 0; m_fd = 0; m_v = 0;
    end else if (ph3 != 0) begin
      m_v = 1;
      if (m_chan != 0) begin m_a = 0; m_b = 1; end
      else begin m_a = 1; m_b = 0; end
      if (m_ref == 0 && m_chan == 0) m_fd = 1;
    end else begin
      m_v = 0;
      if (m_fd == 0 && m_ref == 0 && m_chan == 0) begin
        if (r != 0 && c == 0) m_ref = 1;
        else if (c != 0 && r == 0) m_chan = 1;
      end
    end
  endtask

  task automatic cyc(bit r, bit c, bit ph1, bit ph3, string tag);
    ref_e = r; chan_e = c; p1 = ph1; p3 = ph3;
    @(posedge clk);
    model_step(r, c, ph1, ph3);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang exp finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    // ref first, late channel strobe blocked
    cyc(0,0,1,0,"R4");
    cyc(1,0,0,0,"R2");
    cyc(0,1,0,0,"R2");
    cyc(0,0,0,1,"R3");
    cyc(0,0,0,0,"R7");
    // strobe inside ph1 ignored -> forced
    cyc(0,1,1,0,"R4");
    cyc(0,0,0,1,"R6");
    cyc(0,0,0,0,"R6");
    // channel first
    cyc(0,0,1,0,"R6");
    cyc(0,1,0,0,"R2");
    cyc(1,0,0,0,"R2");
    cyc(0,0,0,0,"R8");
    cyc(0,0,0,1,"R3");
    cyc(0,0,1,0,"R8");
    cyc(0,0,0,0,"R8");
    // same-cycle tie
    cyc(1,1,0,0,"R5");
    cyc(0,0,0,1,"R5");
    // strobe while forced, then repeat phase 3
    cyc(0,1,0,0,"R10");
    cyc(0,0,0,1,"R10");
    // strobe in the phase-3 cycle
    cyc(0,0,1,0,"R4");
    cyc(0,1,0,1,"R10");
    cyc(0,0,0,0,"R10");
    // ph1 and ph3 together
    cyc(1,0,1,1,"R9");
    cyc(0,1,0,0,"R2");
    cyc(0,0,0,1,"R3");
    // tie after one side already won
    cyc(0,0,1,0,"R4");
    cyc(1,0,0,0,"R2");
    cyc(1,1,0,0,"R5");
    cyc(0,0,0,1,"R3");
    // alternating rounds
    for (int i = 0; i < 6; i++) begin
      cyc(0,0,1,0,"R4");
      cyc(0,0,0,0,"R8");
      if (i % 2 == 0) cyc(0,1,0,0,"R2"); else cyc(1,0,0,0,"R2");
      cyc(i % 2 == 0, i % 2 != 0, 0,0,"R2");
      cyc(0,0,0,1,"R3");
      cyc(0,0,0,0,"R7");
    end
    // asynchronous reset in mid-round
    cyc(0,0,1,0,"R4");
    cyc(0,1,0,0,"R2");
    rst_n = 1'b0;
    #1;
    model_step(0,0,0,0);
    check("R1");
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    cyc(0,0,0,1,"R6");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule